// File: doc/BRIEF.md
# UART Interrupt Pending and Mask Unit

This block collects the four interrupt causes of one UART channel (receive, error, transmit, modem-status change) and drives one combined interrupt line. The receiver, the transmitter and the modem-status logic each deliver a single-cycle event strobe. Every strobe records into two 4-bit registers:

- a raw source register, which captures each event whatever the mask;
- a masked pending register, which captures only events whose source is unmasked in the cycle the event arrives.

Software reaches the raw register, the pending register, the mask and a modem-control register through a simple register port. Reads are combinational and writes take effect on a clock edge. Both pending registers are cleared by writing ones, each independently of the other. A handled source is therefore cleared by writing its bit to both.

The modem source is gated a second time, by an enable bit in the modem-control register. While that bit is 0, modem events are dropped before they reach either pending register. The interrupt line is high whenever any masked pending bit is set.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset:
  - the raw and pending registers read 0;
  - the mask reads 0xF (all sources masked);
  - the modem-control register reads 0;
  - irq is 0.
- R2: Source bit positions are receive = bit 0, error = bit 1, transmit = bit 2, modem = bit 3. The register addresses are:
  - 0: raw source pending;
  - 1: masked pending;
  - 2: mask;
  - 3: modem control, where bit 3 is the modem interrupt enable and every other bit reads 0.
- R3: An event strobe sets its raw bit on the next clock edge, whether or not the source is masked.
- R4: An event sets its pending bit only if its mask bit is 0 in that cycle. Later changes to the mask neither set nor clear pending bits.
- R5: Writing to address 0 clears every raw bit written as 1. Bits written as 0 are unchanged, and the pending register is untouched.
- R6: Writing to address 1 clears every pending bit written as 1. Bits written as 0 are unchanged, and the raw register is untouched.
- R7: While modem-control bit 3 is 0, a modem event sets neither the raw nor the pending bit of the modem source.
- R8: irq is 1 exactly when at least one pending bit is 1.
- R9: When an event and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R10: The mask register stores the low 4 bits written to address 2. Its upper read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_rx | input | 1 | Receive event strobe |
| ev_err | input | 1 | Receive error event strobe |
| ev_tx | input | 1 | Transmit event strobe |
| ev_modem | input | 1 | Modem-status change strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for reg_addr (combinational) |
| irq | output | 1 | Combined interrupt |

## Verification
The bench sweeps every combination of the following:
- all 16 mask values;
- all 16 simultaneous event patterns;
- both settings of the modem enable.

This separates capture into the raw register, which ignores the mask, from capture into the pending register, which honours it. It also isolates the modem gate from the ordinary mask. Each case then clears a different bit pattern from each register in turn, so a clear that leaks into the other register, or a bit that clears under a 0, shows up. It also flips the mask after capture, which exposes any pending bit that follows the mask. Dedicated cases put an event and a clear in the same cycle, and write all ones to the mask and modem-control registers.

// File: rtl/uart_irq_pkg.sv
// Shared types for the UART interrupt pending unit.
// Assumes four sources in a fixed bit order.
package uart_irq_pkg;
    localparam int NSRC         = 4;
    localparam int MCTL_IEN_BIT = 3;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef enum logic [1:0] {
        SRC_RX    = 2'd0,
        SRC_ERR   = 2'd1,
        SRC_TX    = 2'd2,
        SRC_MODEM = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        REG_RAW  = 2'd0,
        REG_PEND = 2'd1,
        REG_MASK = 2'd2,
        REG_MCTL = 2'd3
    } reg_e;
endpackage

// File: rtl/uart_irq_decode.sv
// Register access decoder.
// Turns a write strobe, an address and data into per-register strobes.
// Assumes an address with non-zero bits above bit 1 selects no register.
module uart_irq_decode
    import uart_irq_pkg::*;
#(
    parameter int AW = 2,
    parameter int DW = 8
) (
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          hit,
    output reg_e          sel,
    output src_vec_t      clr_raw,
    output src_vec_t      clr_pend,
    output logic          mask_we,
    output logic          mctl_we
);
    logic hi_zero;

    // Upper address bits must be zero for a register hit.
    generate
        if (AW > 2) begin : g_hi
            assign hi_zero = ~|addr[AW-1:2];
        end else begin : g_nohi
            assign hi_zero = 1'b1;
        end
    endgenerate

    assign hit = hi_zero;
    assign sel = reg_e'(addr[1:0]);

    // Per-register write strobes and write-one clear vectors.
    always_comb begin
        clr_raw  = '0;
        clr_pend = '0;
        mask_we  = 1'b0;
        mctl_we  = 1'b0;
        if (wr && hit) begin
            unique case (sel)
                REG_RAW:  clr_raw  = wdata[NSRC-1:0];
                REG_PEND: clr_pend = wdata[NSRC-1:0];
                REG_MASK: mask_we  = 1'b1;
                REG_MCTL: mctl_we  = 1'b1;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/uart_irq_cfg.sv
// Configuration registers: the source mask and the modem interrupt enable.
// Assumes DW covers NSRC bits and the enable bit position.
module uart_irq_cfg
    import uart_irq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mask_we,
    input  logic          mctl_we,
    input  logic [DW-1:0] wdata,
    output src_vec_t      mask_q,
    output logic          modem_en
);
    // Mask register; resets with every source masked.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mask_we) mask_q <= wdata[NSRC-1:0];
    end

    // Modem interrupt enable, a single stored bit of the modem-control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       modem_en <= 1'b0;
        else if (mctl_we) modem_en <= wdata[MCTL_IEN_BIT];
    end
endmodule

// File: rtl/uart_irq_w1c_bank.sv
// Bank of sticky bits, each set by an event and cleared by a write of one.
// When set and clear arrive together, set wins.
module uart_irq_w1c_bank
    import uart_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t set,
    input  src_vec_t clr,
    output src_vec_t q
);
    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_bit
            // One sticky bit, set taking priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)      q[i] <= 1'b0;
                else if (set[i]) q[i] <= 1'b1;
                else if (clr[i]) q[i] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/uart_irq_ctrl.sv
// UART interrupt pending and mask unit (top).
// Records event strobes into a raw register (mask ignored) and a masked
// pending register. Exposes both, plus the mask and the modem enable, through
// a register port. Drives irq as the OR of the pending bits.
// Assumes event strobes are synchronous to clk and one cycle wide.
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int AW = 2,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_rx,
    input  logic          ev_err,
    input  logic          ev_tx,
    input  logic          ev_modem,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq
);
    logic     hit, mask_we, mctl_we, modem_en;
    reg_e     sel;
    src_vec_t clr_raw, clr_pend, mask_q, raw_q, pend_q;
    src_vec_t ev_g, pend_set;

    uart_irq_decode #(.AW(AW), .DW(DW)) u_dec (
        .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .hit(hit), .sel(sel), .clr_raw(clr_raw), .clr_pend(clr_pend),
        .mask_we(mask_we), .mctl_we(mctl_we)
    );

    uart_irq_cfg #(.DW(DW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mctl_we(mctl_we),
        .wdata(reg_wdata), .mask_q(mask_q), .modem_en(modem_en)
    );

    // Gather the strobes in source bit order; the modem strobe is gated by its enable.
    always_comb begin
        ev_g            = '0;
        ev_g[SRC_RX]    = ev_rx;
        ev_g[SRC_ERR]   = ev_err;
        ev_g[SRC_TX]    = ev_tx;
        ev_g[SRC_MODEM] = ev_modem & modem_en;
    end

    assign pend_set = ev_g & ~mask_q;

    uart_irq_w1c_bank u_raw (
        .clk(clk), .rst_n(rst_n), .set(ev_g), .clr(clr_raw), .q(raw_q)
    );

    uart_irq_w1c_bank u_pend (
        .clk(clk), .rst_n(rst_n), .set(pend_set), .clr(clr_pend), .q(pend_q)
    );

    // Read data for the addressed register, zero-extended to DW.
    always_comb begin
        reg_rdata = '0;
        if (hit) begin
            unique case (sel)
                REG_RAW:  reg_rdata[NSRC-1:0]   = raw_q;
                REG_PEND: reg_rdata[NSRC-1:0]   = pend_q;
                REG_MASK: reg_rdata[NSRC-1:0]   = mask_q;
                REG_MCTL: reg_rdata[MCTL_IEN_BIT] = modem_en;
                default:  ;
            endcase
        end
    end

    assign irq = |pend_q;
endmodule

// File: rtl/uart_irq_chk.sv
// Checker for uart_irq_ctrl, attached by bind.
// Relates strobes and writes to later register state.
module uart_irq_chk
    import uart_irq_pkg::*;
#(
    parameter int AW = 2,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ev_rx,
    input logic          ev_err,
    input logic          ev_tx,
    input logic          ev_modem,
    input logic          reg_wr,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic          irq,
    input src_vec_t      raw_q,
    input src_vec_t      pend_q,
    input src_vec_t      mask_q,
    input logic          modem_en
);
    src_vec_t ev_c;
    assign ev_c = {ev_modem && modem_en, ev_tx, ev_err, ev_rx};

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            // R3 and R9: an event always leaves its raw bit set.
            a_r3_raw_capture: assert property (@(posedge clk) disable iff (!rst_n)
                ev_c[i] |=> raw_q[i]);

            // R9: an unmasked event leaves its pending bit set, even with a clear.
            a_r9_pend_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
                (ev_c[i] && !mask_q[i]) |=> pend_q[i]);

            // R4: a pending bit rises only from an unmasked event.
            a_r4_pend_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(pend_q[i]) |-> $past(ev_c[i] && !mask_q[i]));

            // R5: a raw bit drops only after a write of one to address 0.
            a_r5_raw_w1c: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(raw_q[i]) |-> $past(reg_wr && reg_addr == AW'(0) && reg_wdata[i]));

            // R6: a pending bit drops only after a write of one to address 1.
            a_r6_pend_w1c: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(pend_q[i]) |-> $past(reg_wr && reg_addr == AW'(1) && reg_wdata[i]));
        end
    endgenerate

    // R7: the modem raw bit rises only when the enable was on.
    a_r7_modem_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_q[SRC_MODEM]) |-> $past(ev_modem && modem_en));

    // R8: the interrupt line drops only after a write to the pending register.
    a_r8_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(reg_wr && reg_addr == AW'(1)));
endmodule

bind uart_irq_ctrl uart_irq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_rx(ev_rx), .ev_err(ev_err), .ev_tx(ev_tx),
    .ev_modem(ev_modem), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .irq(irq), .raw_q(raw_q), .pend_q(pend_q),
    .mask_q(mask_q), .modem_en(modem_en)
);

// File: tb/sim_uart_irq_ctrl.sv
// Sweep bench for uart_irq_ctrl.
module sim_uart_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_rx = 1'b0, ev_err = 1'b0, ev_tx = 1'b0, ev_modem = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    uart_irq_ctrl #(.AW(2), .DW(8)) u0 (
        .clk(clk), .rst_n(rst_n), .ev_rx(ev_rx), .ev_err(ev_err), .ev_tx(ev_tx),
        .ev_modem(ev_modem), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic pulse(input logic [3:0] e);
        @(negedge clk);
        {ev_modem, ev_tx, ev_err, ev_rx} = e;
        @(negedge clk);
        {ev_modem, ev_tx, ev_err, ev_rx} = 4'd0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [3:0] raw_e, pend_e, c1, c2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every register and of irq.
        rd_chk("R1 raw", 2'd0, 8'h00);
        rd_chk("R1 pend", 2'd1, 8'h00);
        rd_chk("R1 mask", 2'd2, 8'h0F);
        rd_chk("R1 mctl", 2'd3, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);

        // Full sweep: modem enable x mask x event pattern.
        for (int en = 0; en < 2; en++) begin
            for (int m = 0; m < 16; m++) begin
                for (int e = 0; e < 16; e++) begin
                    wr(2'd0, 8'hFF);
                    wr(2'd1, 8'hFF);
                    wr(2'd2, 8'(m));
                    wr(2'd3, en[0] ? 8'h08 : 8'h00);
                    pulse(4'(e));
                    raw_e  = 4'(e) & (en[0] ? 4'hF : 4'h7);
                    pend_e = raw_e & ~4'(m);
                    rd_chk("R3 R7 raw capture", 2'd0, {4'd0, raw_e});
                    rd_chk("R4 R7 pend capture", 2'd1, {4'd0, pend_e});
                    chk("R8 irq", {7'd0, irq}, {7'd0, |pend_e});
                    if (e == 0) begin
                        rd_chk("R10 mask read", 2'd2, 8'(m));
                        rd_chk("R2 mctl read", 2'd3, en[0] ? 8'h08 : 8'h00);
                    end
                    // R4: changing the mask leaves pending bits as they are.
                    wr(2'd2, 8'(~m & 15));
                    rd_chk("R4 mask change", 2'd1, {4'd0, pend_e});
                    // R5: clear a pattern from raw only.
                    c1 = 4'((e * 5 + m) & 15);
                    wr(2'd0, {4'hA, c1});
                    raw_e = raw_e & ~c1;
                    rd_chk("R5 raw w1c", 2'd0, {4'd0, raw_e});
                    rd_chk("R5 pend untouched", 2'd1, {4'd0, pend_e});
                    // R6: clear a different pattern from pending only.
                    c2 = 4'((m * 3 + e + en) & 15);
                    wr(2'd1, {4'h5, c2});
                    pend_e = pend_e & ~c2;
                    rd_chk("R6 pend w1c", 2'd1, {4'd0, pend_e});
                    rd_chk("R6 raw untouched", 2'd0, {4'd0, raw_e});
                    chk("R8 irq after clear", {7'd0, irq}, {7'd0, |pend_e});
                end
            end
        end

        // R9: event and clear in the same cycle on both registers.
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h08);
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'hFF);
        @(negedge clk);
        {ev_modem, ev_tx, ev_err, ev_rx} = 4'hF;
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'hFF;
        @(negedge clk);
        {ev_modem, ev_tx, ev_err, ev_rx} = 4'h0;
        reg_wr = 1'b0;
        rd_chk("R9 raw set wins", 2'd0, 8'h0F);
        @(negedge clk);
        {ev_modem, ev_tx, ev_err, ev_rx} = 4'h5;
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'hFF;
        @(negedge clk);
        {ev_modem, ev_tx, ev_err, ev_rx} = 4'h0;
        reg_wr = 1'b0;
        rd_chk("R9 pend set wins", 2'd1, 8'h05);

        // R10 and R2: upper bits of the mask and modem-control registers read zero.
        wr(2'd2, 8'hFF);
        rd_chk("R10 mask upper bits", 2'd2, 8'h0F);
        wr(2'd3, 8'hFF);
        rd_chk("R2 mctl other bits", 2'd3, 8'h08);
        wr(2'd3, 8'hF7);
        rd_chk("R2 mctl enable off", 2'd3, 8'h00);

        finish_run();
    end
endmodule